// File: doc/BRIEF.md
# Generic Command Packet Front End

This block sits between a processor's register bus and a serial display link layer. Software sends generic short and long packets through it and reads back the response bytes that a peripheral returns. Three addresses are decoded. A write-only header word queues one packet. A payload data word pushes to the transmit payload FIFO when written and pops the receive payload FIFO when read. A status word exposes FIFO-empty flags, a read-completion flag and a sticky overflow flag, which software polls.

The block forms a byte stream from each queued header. A short packet takes its two parameter bytes from the header word itself. A long packet sends the header's 16-bit word count as its second and third bytes, followed by exactly that many payload bytes taken from the payload FIFO. Software must load the whole payload before it writes the header. Response bytes from the link layer are packed four to a word and held for software to read. ECC, CRC and the lane-level turnaround are handled downstream.

Top module: `gen_pkt_front`

## Requirements
- R1: The status word (address 2) carries RX payload FIFO empty at bit 1, TX payload FIFO empty at bit 3, command FIFO empty at bit 5, read-done at bit 7 and sticky overflow at bit 9. All other bits read 0. After reset it reads 0x2A.
- R2: A header written to address 0 holds the data type in bits 5:0, the virtual channel (0 to 3) in bits 7:6, and word-count low / parameter 0 in bits 15:8 and word-count high / parameter 1 in bits 23:16. It is sent as three bytes in this order: {vc,dt}, bits 15:8, bits 23:16.
- R3: A data type with bit 3 set and bits 2:0 not all zero is a long packet. After the three header bytes, exactly word-count payload bytes follow. They are taken from the payload FIFO least significant byte first. The unused upper bytes of a partial last word are discarded, and that word is still popped.
- R4: A short packet, or a long packet with a word count of 0, sends only its three header bytes. In that case tx_last is set on the third byte. Otherwise tx_last is set on the final payload byte only.
- R5: A write to address 1 pushes a word to the TX payload FIFO, which clears status bit 3. The FIFO drains only while a long packet is being sent.
- R6: A header write to a full command FIFO, or a payload write to a full TX payload FIFO, is dropped and sets status bit 9. The same applies to a response word that finds the RX FIFO full. Bit 9 stays set until reset.
- R7: Response bytes are packed into 32-bit words least significant byte first. A word is stored when its fourth byte arrives, or when a byte arrives with rx_last set; in that case the unfilled upper bytes are 0.
- R8: Read-done (bit 7) sets in the cycle after a response byte with rx_last is accepted. It clears in the cycle after the next header write.
- R9: A read of address 1 returns the oldest RX word and pops it. A read with the RX FIFO empty returns 0 and changes nothing.
- R10: While tx_valid is high and tx_ready is low, tx_data and tx_last hold their values and tx_valid stays high.
- R11: Header bits 31:24 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at address 1) |
| reg_addr | input | 2 | Register address: 0 header, 1 payload data, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| tx_valid | output | 1 | Packet byte valid towards the link layer |
| tx_ready | input | 1 | Link layer accepts the byte |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| rx_valid | input | 1 | Response byte valid from the link layer |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Final byte of the response |

## Verification
A short write packet has all-ones in the ignored header byte. It separates the parameter-in-header path from the word-count path and shows that bits 31:24 are not sent. Long packets are sent with word counts of 6, 4, 5 and 0, which separates a partial last word, an exactly full last word and the header-only case. The count of 5 is sent under irregular back-pressure, to expose byte loss or repetition at a stall. A 6-byte response followed by reads of the payload address shows the byte packing, the zero fill of a partial word, the read of an empty FIFO and the set and clear of read-done. Finally, the payload FIFO is overfilled and then drained, which shows that the dropped word never appears on the link.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
    localparam logic [1:0] ADDR_HDR  = 2'd0;
    localparam logic [1:0] ADDR_PLD  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_HDR,
        FR_PLD
    } fr_state_e;

    typedef struct packed {
        fr_state_e   st;
        logic [23:0] hdr;
        logic [1:0]  idx;
        logic [1:0]  lane;
        logic [15:0] left;
    } fr_regs_t;

    typedef struct packed {
        logic [23:0] acc;
        logic [1:0]  lane;
        logic        done;
    } rx_regs_t;

    function automatic logic is_long(input logic [5:0] dt);
        return dt[3] && (dt[2:0] != 3'd0);
    endfunction
endpackage

// File: rtl/gpf_fifo.sv
module gpf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t          p_q, p_d;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] v);
        return (v == AW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    assign empty   = (p_q.cnt == '0);
    assign full    = (p_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[p_q.rp];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wp = inc(p_q.wp);
        if (do_pop)  p_d.rp = inc(p_q.rp);
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wp] <= din;
    end
endmodule

// File: rtl/gpf_framer.sv
module gpf_framer
    import gpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_empty,
    input  logic [23:0] cmd_head,
    output logic        cmd_pop,
    input  logic        pld_empty,
    input  logic [31:0] pld_head,
    output logic        pld_pop,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last
);
    fr_regs_t    q, d;
    logic        long_pkt;
    logic [15:0] wc;
    logic [31:0] lane_word;

    assign wc        = q.hdr[23:8];
    assign long_pkt  = is_long(q.hdr[5:0]) && (wc != 16'd0);
    assign lane_word = pld_head >> {q.lane, 3'b000};

    always_comb begin
        d        = q;
        cmd_pop  = 1'b0;
        pld_pop  = 1'b0;
        tx_valid = 1'b0;
        tx_data  = 8'd0;
        tx_last  = 1'b0;
        case (q.st)
            FR_IDLE: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    d.hdr   = cmd_head;
                    d.idx   = 2'd0;
                    d.st    = FR_HDR;
                end
            end
            FR_HDR: begin
                tx_valid = 1'b1;
                case (q.idx)
                    2'd0:    tx_data = q.hdr[7:0];
                    2'd1:    tx_data = q.hdr[15:8];
                    default: tx_data = q.hdr[23:16];
                endcase
                tx_last = (q.idx == 2'd2) && !long_pkt;
                if (tx_ready) begin
                    if (q.idx == 2'd2) begin
                        d.lane = 2'd0;
                        d.left = wc;
                        d.st   = long_pkt ? FR_PLD : FR_IDLE;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            default: begin
                tx_valid = !pld_empty;
                tx_data  = lane_word[7:0];
                tx_last  = (q.left == 16'd1);
                if (tx_valid && tx_ready) begin
                    d.left = q.left - 16'd1;
                    d.lane = q.lane + 2'd1;
                    if (q.lane == 2'd3 || q.left == 16'd1) pld_pop = 1'b1;
                    if (q.left == 16'd1) d.st = FR_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/gpf_rx_pack.sv
module gpf_rx_pack
    import gpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        clr_done,
    input  logic        fifo_full,
    output logic        push,
    output logic [31:0] word,
    output logic        ovf,
    output logic        done
);
    rx_regs_t q, d;

    assign done = q.done;
    assign word = {8'd0, q.acc} | ({24'd0, rx_data} << {q.lane, 3'b000});

    always_comb begin
        d    = q;
        push = 1'b0;
        ovf  = 1'b0;
        if (clr_done) d.done = 1'b0;
        if (rx_valid) begin
            if (q.lane == 2'd3 || rx_last) begin
                push   = !fifo_full;
                ovf    = fifo_full;
                d.acc  = '0;
                d.lane = 2'd0;
            end else begin
                d.acc  = word[23:0];
                d.lane = q.lane + 2'd1;
            end
            if (rx_last) d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/gen_pkt_front.sv
module gen_pkt_front
    import gpf_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int PLD_DEPTH = 4,
    parameter int RX_DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last
);
    logic        hdr_wr, pld_wr, pld_rd;
    logic        cmd_empty, cmd_full, cmd_pop;
    logic [23:0] cmd_head;
    logic        pld_empty, pld_full, pld_pop;
    logic [31:0] pld_head;
    logic        rx_empty, rx_full, rx_push, rx_ovf, rd_done;
    logic [31:0] rx_word, rx_head;
    logic [31:0] stat_w;
    logic        ovf_q, ovf_d;

    assign hdr_wr = reg_wr && (reg_addr == ADDR_HDR);
    assign pld_wr = reg_wr && (reg_addr == ADDR_PLD);
    assign pld_rd = reg_rd && (reg_addr == ADDR_PLD);

    gpf_fifo #(.W(24), .DEPTH(CMD_DEPTH)) u_cmd (
        .clk(clk), .rst_n(rst_n), .push(hdr_wr), .din(reg_wdata[23:0]),
        .pop(cmd_pop), .dout(cmd_head), .empty(cmd_empty), .full(cmd_full)
    );

    gpf_fifo #(.W(32), .DEPTH(PLD_DEPTH)) u_txp (
        .clk(clk), .rst_n(rst_n), .push(pld_wr), .din(reg_wdata),
        .pop(pld_pop), .dout(pld_head), .empty(pld_empty), .full(pld_full)
    );

    gpf_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rxp (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
        .pop(pld_rd), .dout(rx_head), .empty(rx_empty), .full(rx_full)
    );

    gpf_framer u_fr (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
        .pld_empty(pld_empty), .pld_head(pld_head), .pld_pop(pld_pop),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last)
    );

    gpf_rx_pack u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .clr_done(hdr_wr), .fifo_full(rx_full),
        .push(rx_push), .word(rx_word), .ovf(rx_ovf), .done(rd_done)
    );

    always_comb begin
        ovf_d = ovf_q | (hdr_wr && cmd_full) | (pld_wr && pld_full) | rx_ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign stat_w = {22'd0, ovf_q, 1'b0, rd_done, 1'b0, cmd_empty, 1'b0,
                     pld_empty, 1'b0, rx_empty, 1'b0};

    always_comb begin
        case (reg_addr)
            ADDR_PLD:  reg_rdata = rx_empty ? 32'd0 : rx_head;
            ADDR_STAT: reg_rdata = stat_w;
            default:   reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/gpf_chk.sv
module gpf_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic        rx_valid,
    input logic        rx_last,
    input logic [31:0] stat
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat[9] |=> stat[9]);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && !(rx_valid && rx_last)) |=> !stat[7]);

    assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_last) |=> stat[7]);

    assert_spare_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[31:10] == 22'd0) && !stat[8] && !stat[6] && !stat[4] && !stat[2] && !stat[0]);
endmodule

bind gen_pkt_front gpf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_last(rx_last), .stat(stat_w)
);

// File: tb/sim_gen_pkt_front.sv
`timescale 1ns/1ps
module sim_gen_pkt_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = 8'd0;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [8:0] expq[$];

    always #2.5 clk = ~clk;

    gen_pkt_front u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each accepted link byte with the queue
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (expq.size() == 0) begin
                check("R2 unexpected byte", {23'd0, tx_last, tx_data}, 32'h1ff);
            end else begin
                check("R2/R3/R4 byte", {23'd0, tx_last, tx_data}, {23'd0, expq.pop_front()});
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // driver: queues a packet's expected bytes, then writes its header
    task automatic send_pkt(input logic [31:0] hdr, input logic [7:0] pl[$]);
        logic long_p;
        long_p = hdr[3] && (hdr[2:0] != 3'd0) && (hdr[23:8] != 16'd0);
        expq.push_back({1'b0, hdr[7:0]});
        expq.push_back({1'b0, hdr[15:8]});
        expq.push_back({!long_p, hdr[23:16]});
        if (long_p)
            for (int i = 0; i < pl.size(); i++)
                expq.push_back({i == pl.size() - 1, pl[i]});
        wr(2'd0, hdr);
    endtask

    task automatic drain();
        while (expq.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic rx_byte(input logic [7:0] b, input logic l);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b; rx_last = l;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0] pl[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        rd(2'd2, v); check("R1 status after reset", v, 32'h2A);

        // short packet, vc=1 dt=0x15, junk in bits 31:24 (R11)
        pl = {};
        send_pkt(32'hFFCD_AB55, pl);
        drain();
        check("R11 short packet fully consumed", expq.size(), 0);

        // long, wc=6: partial last word, upper bytes dropped (R3)
        wr(2'd1, 32'h4433_2211);
        wr(2'd1, 32'hEEFF_6655);
        rd(2'd2, v); check("R5 payload fifo not empty", {31'd0, v[3]}, 32'd0);
        pl = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        send_pkt(32'h0000_0639, pl);
        drain();
        rd(2'd2, v); check("R3 payload fifo drained", v, 32'h2A);

        // long, wc=4 exactly one word
        wr(2'd1, 32'hDDCC_BBAA);
        pl = {8'hAA, 8'hBB, 8'hCC, 8'hDD};
        send_pkt(32'h0000_0479, pl);
        drain();

        // long with wc=0: header only (R4)
        pl = {};
        send_pkt(32'h0000_0029, pl);
        drain();
        rd(2'd2, v); check("R4 status idle", v, 32'h2A);

        // back-pressure, wc=5 (R10)
        wr(2'd1, 32'h0403_0201);
        wr(2'd1, 32'h0000_0005);
        pl = {8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        send_pkt(32'h0000_05B9, pl);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            tx_ready = (i % 3 != 0);
        end
        tx_ready = 1'b1;
        drain();
        check("R10 all bytes delivered under stalls", expq.size(), 0);

        // read request then response
        pl = {};
        send_pkt(32'h0000_0A14, pl);
        drain();
        rd(2'd2, v); check("R8 done low before response", {31'd0, v[7]}, 32'd0);
        for (int i = 1; i <= 6; i++) rx_byte(8'(i), i == 6);
        rd(2'd2, v); check("R8 done set after last", v, 32'hA8);
        rd(2'd1, v); check("R7 first word", v, 32'h0403_0201);
        rd(2'd1, v); check("R7 partial word zero filled", v, 32'h0000_0605);
        rd(2'd2, v); check("R9 rx empty after pops", v, 32'hAA);
        rd(2'd1, v); check("R9 empty read returns 0", v, 32'd0);
        rd(2'd2, v); check("R9 empty read no effect", v, 32'hAA);
        send_pkt(32'h0000_0005, pl);
        drain();
        rd(2'd2, v); check("R8 done cleared by header", v, 32'h2A);

        // overflow of the payload fifo (R6)
        for (int i = 0; i < 5; i++) wr(2'd1, {4{8'(8'h10 + i)}});
        rd(2'd2, v); check("R6 overflow flag set", v, 32'h200 | 32'h22);
        pl = {};
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 4; b++) pl.push_back(8'(8'h10 + w));
        send_pkt(32'h0000_1039, pl);
        drain();
        rd(2'd2, v); check("R6 sticky after drain, dropped word absent", v, 32'h22A);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule